// File: doc/BRIEF.md
# Power-State Sequencer with Stabilization Timer

This block decides when a small controller's processor and peripherals receive clock. It holds one of four states: run, idle, wait and stop. A stop command turns off both clock enables. A light-sleep command turns off only the processor clock. Once stop has been entered, an interrupt or a reset is the only way out, and neither one goes straight back to run. Both first pass through a wait state. In wait the peripheral and timer clock is running and the processor clock is off, and the block stays there until an 8-bit timer overflows.

The timer is driven through a prescaler, and a 2-bit select input picks the division ratio. An interrupt wake captures the select value on the wake edge and restarts the timer from zero. A reset always uses the longest ratio, which gives a 65536-cycle stabilization. In run the same timer works as a watchdog: if software does not pulse the clear input before the timer overflows, the block raises a one-cycle reset request.

Top module: `pwr_stab_ctrl`

## Requirements
- R1: While reset is held, the block sits in wait with the processor enable low, the peripheral enable high and the watchdog request low. After reset is released, the block reaches run after exactly 65536 rising clock edges, whatever the select input holds. This also applies to a reset taken while stopped.
- R2: The state output encodes run as 0, idle as 1, wait as 2 and stop as 3. The processor clock enable is high only in run. The peripheral clock enable is low only in stop.
- R3: In run, a stop command moves the block to stop on the next edge. If the stop command and the idle command arrive on the same edge, stop takes priority.
- R4: In run, an idle command without a stop command moves the block to idle on the next edge. In idle, an interrupt returns the block to run on the next edge, with no stabilization wait.
- R5: In stop, the block stays put until an interrupt arrives. On that edge it enters wait with the timer cleared, and it reaches run 2^(D+8) edges later. D is 1, 3, 5 or 8 for select values 0, 1, 2 and 3, and the select is sampled on the wake edge.
- R6: Commands, interrupts, watchdog clears and select changes have no effect while in wait: the wait length stays as captured. Stop and idle commands have no effect in idle.
- R7: In run, the watchdog request goes high for exactly one cycle once 2^(D+8) edges have passed since the edge that applied the last clear, with D taken from the live select input.
- R8: A clear that lands on the same edge as the overflow suppresses the request and starts a fresh window.
- R9: The watchdog raises no request in idle or in stop, however long the block stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset, also a stop wake source |
| stop_cmd | input | 1 | Request to enter stop |
| idle_cmd | input | 1 | Request to enter idle |
| irq_wake | input | 1 | Interrupt wake from idle or stop |
| wd_clr | input | 1 | Watchdog clear pulse, used only in run |
| psel | input | 2 | Prescaler select |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral and timer clock enable |
| wd_rst | output | 1 | One-cycle watchdog reset request |
| pstate | output | 2 | Current power state |

## Verification
The watchdog clear and the timer overflow can fall on the same edge. The bench clears the timer and counts out 512 edges at the shortest ratio. It then holds the clear on edge 513, which is the overflow edge, and checks two things: no request appears, and the next request arrives a full 512 edges later. A stop command and an idle command can also coincide in run, and so can an interrupt with a command during wait. The bench drives each of these pairs together and judges the result by the resulting state and by the measured length of the wait.

// File: rtl/pwr_stab_ctrl.sv
module pwr_stab_ctrl #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 8,
  parameter int DIV0  = 1,
  parameter int DIV1  = 3,
  parameter int DIV2  = 5,
  parameter int DIV3  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_cmd,
  input  logic       idle_cmd,
  input  logic       irq_wake,
  input  logic       wd_clr,
  input  logic [1:0] psel,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       wd_rst,
  output logic [1:0] pstate
);
  localparam logic [1:0] S_RUN  = 2'd0;
  localparam logic [1:0] S_IDLE = 2'd1;
  localparam logic [1:0] S_WAIT = 2'd2;
  localparam logic [1:0] S_STOP = 2'd3;
  localparam logic [PRE_W-1:0] LIM0 = PRE_W'((32'd1 << DIV0) - 32'd1);
  localparam logic [PRE_W-1:0] LIM1 = PRE_W'((32'd1 << DIV1) - 32'd1);
  localparam logic [PRE_W-1:0] LIM2 = PRE_W'((32'd1 << DIV2) - 32'd1);
  localparam logic [PRE_W-1:0] LIM3 = PRE_W'((32'd1 << DIV3) - 32'd1);

  logic [1:0]       st, wsel, use_sel;
  logic [PRE_W-1:0] pre, lim;
  logic [CNT_W-1:0] cnt;
  logic             wd_q;

  assign use_sel = (st == S_WAIT) ? wsel : psel;

  always_comb begin
    case (use_sel)
      2'd0:    lim = LIM0;
      2'd1:    lim = LIM1;
      2'd2:    lim = LIM2;
      default: lim = LIM3;
    endcase
  end

  wire tick     = (pre >= lim);
  wire ovf      = tick && (cnt == {CNT_W{1'b1}});
  wire counting = (st == S_RUN) || (st == S_WAIT);
  wire restart  = ((st == S_STOP) && irq_wake) || ((st == S_RUN) && wd_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_WAIT;
      wsel <= 2'd3;
      pre  <= '0;
      cnt  <= '0;
      wd_q <= 1'b0;
    end else begin
      wd_q <= (st == S_RUN) && ovf && !wd_clr;
      case (st)
        S_RUN:  if (stop_cmd) st <= S_STOP;
                else if (idle_cmd) st <= S_IDLE;
        S_IDLE: if (irq_wake) st <= S_RUN;
        S_STOP: if (irq_wake) begin
                  st   <= S_WAIT;
                  wsel <= psel;
                end
        default: if (ovf) st <= S_RUN;
      endcase
      if (restart) begin
        pre <= '0;
        cnt <= '0;
      end else if (counting) begin
        if (tick) begin
          pre <= '0;
          cnt <= cnt + 1'b1;
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end
  end

  assign cpu_clk_en = (st == S_RUN);
  assign per_clk_en = (st != S_STOP);
  assign wd_rst     = wd_q;
  assign pstate     = st;
endmodule

// File: rtl/pwr_stab_ctrl_chk.sv
module pwr_stab_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_cmd,
  input logic       irq_wake,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       wd_rst,
  input logic [1:0] pstate
);
  assert_cpu_needs_per_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> per_clk_en);
  assert_stop_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd0 && stop_cmd) |=> (pstate == 2'd3));
  assert_idle_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd1 && irq_wake) |=> (pstate == 2'd0));
  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd3 && !irq_wake) |=> (pstate == 2'd3));
  assert_stop_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd3 && irq_wake) |=> (pstate == 2'd2));
  assert_wd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> !wd_rst);
  assert_wd_run_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |-> ($past(pstate) == 2'd0));
endmodule

bind pwr_stab_ctrl pwr_stab_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_cmd(stop_cmd), .irq_wake(irq_wake),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .wd_rst(wd_rst),
  .pstate(pstate)
);

// File: tb/tb_pwr_stab_ctrl.sv
module tb_pwr_stab_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, stop_cmd = 1'b0, idle_cmd = 1'b0;
  logic       irq_wake = 1'b0, wd_clr = 1'b0;
  logic [1:0] psel = 2'd3;
  logic       cpu_clk_en, per_clk_en, wd_rst;
  logic [1:0] pstate;

  pwr_stab_ctrl dut (
    .clk(clk), .rst_n(rst_n), .stop_cmd(stop_cmd), .idle_cmd(idle_cmd),
    .irq_wake(irq_wake), .wd_clr(wd_clr), .psel(psel),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .wd_rst(wd_rst),
    .pstate(pstate)
  );

  int errs = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic measure(input logic [1:0] tgt, output int k);
    k = 0;
    do begin
      step();
      k++;
    end while (pstate !== tgt && k < 70000);
  endtask

  function automatic int span(input int s);
    case (s)
      0: return 1 << 9;
      1: return 1 << 11;
      2: return 1 << 13;
      default: return 1 << 16;
    endcase
  endfunction

  initial begin
    int k, k2, seen;
    repeat (3) step();
    chk("R1 reset state", pstate, 2);
    chk("R2 reset cpu_en", cpu_clk_en, 0);
    chk("R2 reset per_en", per_clk_en, 1);
    chk("R1 reset wd_rst", wd_rst, 0);
    psel = 2'd0;
    rst_n = 1'b1;
    measure(2'd0, k);
    chk("R1 reset wait length", k, 65536);
    chk("R2 run cpu_en", cpu_clk_en, 1);
    psel = 2'd3;

    idle_cmd = 1'b1; step(); idle_cmd = 1'b0;
    chk("R4 idle entry", pstate, 1);
    chk("R2 idle cpu_en", cpu_clk_en, 0);
    chk("R2 idle per_en", per_clk_en, 1);
    stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
    chk("R6 stop ignored in idle", pstate, 1);
    seen = 0;
    repeat (3000) begin step(); seen += int'(wd_rst); end
    chk("R9 no watchdog in idle", seen, 0);
    irq_wake = 1'b1; step(); irq_wake = 1'b0;
    chk("R4 idle exit", pstate, 0);

    for (int s = 0; s < 3; s++) begin
      stop_cmd = 1'b1; idle_cmd = 1'b1; step();
      stop_cmd = 1'b0; idle_cmd = 1'b0;
      chk("R3 stop wins", pstate, 3);
      chk("R2 stop per_en", per_clk_en, 0);
      seen = 0;
      repeat (50) begin step(); seen += int'(wd_rst); end
      chk("R5 stop holds", pstate, 3);
      chk("R9 no watchdog in stop", seen, 0);
      psel = 2'(s);
      irq_wake = 1'b1; step(); irq_wake = 1'b0;
      k = 1;
      chk("R5 wake to wait", pstate, 2);
      if (s == 1) begin
        psel = 2'd3; irq_wake = 1'b1; stop_cmd = 1'b1; wd_clr = 1'b1;
        step(); k++;
        irq_wake = 1'b0; stop_cmd = 1'b0; wd_clr = 1'b0;
        chk("R6 wait holds under stimulus", pstate, 2);
      end
      measure(2'd0, k2);
      k += k2;
      chk(s == 1 ? "R6 wait length unchanged" : "R5 wait length", k, span(s) + 1);
    end

    psel = 2'd0;
    wd_clr = 1'b1; step(); wd_clr = 1'b0;
    k = 1;
    while (!wd_rst && k < 2000) begin step(); k++; end
    chk("R7 watchdog window", k, 513);
    step();
    chk("R7 watchdog one cycle", wd_rst, 0);

    wd_clr = 1'b1; step(); wd_clr = 1'b0;
    seen = 0;
    repeat (511) begin step(); seen += int'(wd_rst); end
    wd_clr = 1'b1; step(); wd_clr = 1'b0;
    seen += int'(wd_rst);
    chk("R8 clear on overflow edge suppresses", seen, 0);
    k = 0;
    while (!wd_rst && k < 2000) begin step(); k++; end
    chk("R8 fresh window after collision", k, 512);

    psel = 2'd3;
    stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
    chk("R3 stop entry", pstate, 3);
    psel = 2'd0;
    rst_n = 1'b0; step();
    chk("R1 reset from stop", pstate, 2);
    rst_n = 1'b1;
    measure(2'd0, k);
    chk("R1 reset from stop wait length", k, 65536);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule